// File: doc/BRIEF.md
# Sequential Signed Add-Shift Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It works one multiplier bit per clock. A high accumulator register takes each partial product through a single-precision adder or subtractor. A low register starts out holding the multiplier. After each step the two registers shift right together, with the sign preserved. The next multiplier bit drops out of the low register into the decision logic, and a finished product bit moves in at the top.

A caller raises `start` for one cycle with the operands on `mcand_i` and `mplier_i` while the block is not busy. The block copies the operands on that edge. It asserts `busy_o` for exactly `WIDTH` cycles and then raises `done_o` for one cycle. From that cycle on, `product_o` holds the result until the next accepted start. The partial product of the multiplier's sign bit carries weight `-2^(WIDTH-1)`, so the block subtracts the multiplicand for that bit instead of adding it. This lets a negative multiplier work without negating the operands first.

The controller has three states. `ST_IDLE` waits for a start. `ST_RUN` performs one add-or-subtract-then-shift step per cycle. `ST_FIN` presents the result. The transitions are as follows:
- idle-to-run on an accepted start
- run-to-run while the step counter is below `WIDTH-1`
- run-to-fin on the last step
- fin-to-run on a start in the result cycle
- fin-to-idle otherwise

Top module: `signed_shift_mul`

## Requirements
- R1: After reset, or while `rst_n` is low, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A high `start` sampled on a clock edge while `busy_o` is 0 is accepted and copies `mcand_i` and `mplier_i`. `busy_o` is 1 in the following cycle.
- R3: After an accepted start, `busy_o` stays high for exactly `WIDTH` cycles. `done_o` rises in the cycle right after the last busy cycle.
- R4: `done_o` is high for a single cycle per operation, and never in the same cycle as `busy_o`.
- R5: For a non-negative multiplier, `product_o` in the `done_o` cycle equals the signed product as a `2*WIDTH`-bit two's-complement value. This holds for any sign of the multiplicand.
- R6: For a negative multiplier, the sign-bit partial product is subtracted. The product is still the exact signed product; with `WIDTH`=4, 5 times -6 gives 8'b1110_0010.
- R7: The most negative operand times the most negative operand gives `+2^(2*WIDTH-2)`. With `WIDTH`=4 this is 8'h40; with `WIDTH`=8 it is 16'h4000.
- R8: While `busy_o` is high, `start` and any change on `mcand_i` or `mplier_i` have no effect on the running operation or its result.
- R9: Once `done_o` has been seen, `product_o` stays unchanged until the next accepted start, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only when not busy |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | High during the WIDTH step cycles |
| done_o | output | 1 | One-cycle pulse, product valid |
| product_o | output | 2*WIDTH | Signed product, high half from accumulator |

## Verification
The hardest case to reach is the last step with a most-negative multiplicand and a multiplier whose sign bit is set. There, the subtraction in the accumulator exceeds the single-precision range, and only the extra intermediate bit gives the right sign to shift in. The stimulus table places extreme operands on both inputs, and a directed case squares the most negative value at both 8 and 4 bits. A second case that is awkward to produce is a start raised in the middle of a run. The bench raises one together with fresh operand values partway through an operation and checks that both the busy length and the original product are unchanged.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    smul_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          accept;
    logic          at_last;

    assign accept  = start_i && (state_q != ST_RUN);
    assign at_last = (cnt_q == LAST_IDX);

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_FIN;
            ST_FIN:  state_d = accept ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = accept;
        step_o = 1'b0;
        last_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
                last_o = at_last;
            end
            ST_FIN:  done_o = 1'b1;
            default: ;
        endcase
    end

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r3_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && last_o) |=> done_o);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q < CW'(WIDTH)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o);

endmodule

// File: rtl/smul_step.sv
module smul_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             bit_i,
    input  logic             sub_i,
    output logic [WIDTH:0]   sum_o
);

    logic [WIDTH:0] acc_ext;
    logic [WIDTH:0] mc_ext;

    // one guard bit keeps the true sign of the step result
    assign acc_ext = {acc_i[WIDTH-1], acc_i};
    assign mc_ext  = {mcand_i[WIDTH-1], mcand_i};

    always_comb begin
        if (!bit_i) begin
            sum_o = acc_ext;
        end else if (sub_i) begin
            sum_o = acc_ext - mc_ext;
        end else begin
            sum_o = acc_ext + mc_ext;
        end
    end

endmodule

// File: rtl/smul_dp.sv
module smul_dp #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               last_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o
);

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] low_q;
    logic [WIDTH:0]   sum;

    smul_step #(.WIDTH(WIDTH)) u_step (
        .acc_i   (acc_q),
        .mcand_i (mcand_q),
        .bit_i   (low_q[0]),
        .sub_i   (last_i),
        .sum_o   (sum)
    );

    // low register starts as multiplier and fills with product bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            low_q   <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
            acc_q   <= '0;
            low_q   <= mplier_i;
        end else if (step_i) begin
            acc_q <= sum[WIDTH:1];
            low_q <= {sum[0], low_q[WIDTH-1:1]};
        end
    end

    assign product_o = {acc_q, low_q};

    a_r8_mcand_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !last_i) |=> $stable(mcand_q));

    a_r9_product_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(product_o));

endmodule

// File: rtl/signed_shift_mul.sv
module signed_shift_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    logic load;
    logic step;
    logic last;

    smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    smul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .last_i    (last),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && product_o == '0));

endmodule

// File: tb/test_signed_shift_mul.sv
module test_signed_shift_mul;

    localparam int W  = 8;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0] mc = '0;
    logic signed [W-1:0] mp = '0;
    logic busy, done;
    logic [2*W-1:0] prod;

    logic start4 = 1'b0;
    logic [3:0] mc4 = '0;
    logic [3:0] mp4 = '0;
    logic busy4, done4;
    logic [7:0] prod4;

    int tests  = 0;
    int failed = 0;

    always #5 clk = ~clk;

    signed_shift_mul #(.WIDTH(W)) i_signed_shift_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand_i(mc), .mplier_i(mp),
        .busy_o(busy), .done_o(done), .product_o(prod)
    );

    signed_shift_mul #(.WIDTH(4)) i_signed_shift_mul_n4 (
        .clk(clk), .rst_n(rst_n), .start(start4), .mcand_i(mc4), .mplier_i(mp4),
        .busy_o(busy4), .done_o(done4), .product_o(prod4)
    );

    localparam logic signed [W-1:0] TA [NV] = '{
        8'sd5, 8'sd0, 8'sd1, 8'sd127, -8'sd128, 8'sd127, -8'sd1,
        -8'sd128, -8'sd1, 8'sd100, -8'sd77, 8'sd0, 8'sd85};
    localparam logic signed [W-1:0] TB [NV] = '{
        -8'sd6, 8'sd0, 8'sd1, 8'sd127, 8'sd127, -8'sd128, -8'sd1,
        -8'sd1, -8'sd128, -8'sd3, 8'sd55, -8'sd128, -8'sd86};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_mul(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                          input string req);
        int nb;
        longint e;
        e = longint'(a) * longint'(b);
        @(negedge clk);
        start = 1'b1; mc = a; mp = b;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (!done && nb < W + 4) begin
            if (busy) nb++;
            @(negedge clk);
        end
        check(nb == W, "R3 busy length", nb, W);
        check(done && !busy, "R4 done pulse", done, 1);
        check(prod == 16'(e), req, longint'($signed(prod)), e);
        @(negedge clk);
        check(!done, "R4 single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && prod == '0, "R1 reset", prod, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", busy, 0);

        // R5 / R6: table of operand pairs
        for (int i = 0; i < NV; i++) begin
            do_mul(TA[i], TB[i], TB[i] < 0 ? "R6 negative multiplier" : "R5 product");
        end

        // R7: most negative squared
        do_mul(-8'sd128, -8'sd128, "R7 min times min");
        check(prod == 16'h4000, "R7 exact pattern", prod, 16'h4000);

        // R2 / R8: start and operand changes during a run
        @(negedge clk);
        start = 1'b1; mc = 8'sd3; mp = 8'sd4;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R2 busy after start", busy, 1);
        @(negedge clk);
        start = 1'b1; mc = -8'sd50; mp = 8'sd99;
        @(negedge clk);
        start = 1'b0;
        nb = 2;
        while (!done && nb < W + 4) begin
            if (busy) nb++;
            @(negedge clk);
        end
        check(nb == W, "R8 busy length unchanged", nb, W);
        check(prod == 16'd12, "R8 start ignored", prod, 12);

        // R9: result holds while operands move
        for (int k = 0; k < 5; k++) begin
            mc = 8'(k * 37); mp = 8'(k * 11 + 1);
            @(negedge clk);
            check(prod == 16'd12 && !busy, "R9 product held", prod, 12);
        end

        // R6 / R7 at 4 bits
        @(negedge clk);
        start4 = 1'b1; mc4 = 4'd5; mp4 = 4'b1010;
        @(negedge clk);
        start4 = 1'b0;
        nb = 0;
        while (!done4 && nb < 10) begin nb++; @(negedge clk); end
        check(prod4 == 8'b1110_0010, "R6 5 x -6 at 4 bits", prod4, 8'hE2);
        @(negedge clk);
        start4 = 1'b1; mc4 = 4'b1000; mp4 = 4'b1000;
        @(negedge clk);
        start4 = 1'b0;
        nb = 0;
        while (!done4 && nb < 10) begin nb++; @(negedge clk); end
        check(prod4 == 8'h40, "R7 -8 x -8 at 4 bits", prod4, 8'h40);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; mc = 8'sd9; mp = 8'sd9;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && prod == '0, "R1 reset mid run", prod, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule